// File: doc/BRIEF.md
# Miss Response Classifier with Ack Counting

This block keeps a small table of outstanding cache misses and turns each incoming coherence response into one controller event. Every table entry records the line address, the transient coherence state, a copy of the line data, a dirty bit, a prefetch flag and a signed count of acknowledgements still owed. The main cache controller allocates an entry when a miss starts and frees it when the miss ends. It receives a registered event for every response and for every forwarded request it hands to this block.

Data and ack responses are sorted into partial and final kinds by a single test. The count carried in the message is subtracted from the stored count, and the result is checked for zero. The stored count is then replaced by that result. Plain data sent by a peer first-level cache during a read miss gets its own event, because the controller must answer it with a plain unblock. Forwarded requests are decoded here as well. A forwarded upgrade is folded into the exclusive-request event, and an invalidation comes with the ack count of one that the reply must carry.

Top module: `miss_resp_classifier`

## Requirements
- R1: After reset no entry is valid, and `alloc_gnt`, `alloc_stall`, `rsp_ev_valid`, `fwd_ev_valid` and `proto_err` are all low.
- R2: An allocation request is granted on the next clock edge to the lowest-numbered free entry. That entry then reads back the request's address, data, dirty bit, prefetch flag and state, with an ack count of zero.
- R3: An allocation request while every entry is valid raises `alloc_stall` for one cycle, and `alloc_gnt` stays low.
- R4: Freeing an entry clears its valid bit, and the next allocation may reuse that index.
- R5: A response of type 1 (exclusive data) gives event 1, and type 3 (writeback ack) gives event 7. Both events appear one cycle after the response, and neither changes the stored count.
- R6: Type 0 (plain data) with `rsp_from_l1` high gives event 2 when `line_state` is 5 (read miss) or 8 (read miss, invalidated), and the stored count is left unchanged.
- R7: Any other type 0 response gives event 3 when stored count minus carried count is zero, and event 4 otherwise. The stored count becomes that difference.
- R8: A type 2 (ack) response gives event 5 when stored count minus carried count is zero, and event 6 otherwise. The stored count becomes that difference.
- R9: The count is signed two's complement, so acks that arrive before the data take it below zero without wrapping. `rsp_cnt_after` reports the count after the update.
- R10: On the next clock edge, forwarded type 0 (invalidate) gives event 8 with `fwd_ack_cnt` = 1. Types 1 (exclusive) and 2 (upgrade) both give event 9. Type 3 (shared read) gives event 10, and type 4 (instruction read) gives event 11. `fwd_ack_cnt` is 0 for every event except event 8.
- R11: `proto_err` pulses one cycle later, with no event valid for that message, in three cases: a response type of 4 to 7, a forwarded type of 5 to 7, or a response that names an entry which is not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Request a new entry |
| alloc_addr | input | ADDR_W | Line address for the new entry |
| alloc_data | input | DATA_W | Current line data copied into the entry |
| alloc_dirty | input | 1 | Current dirty bit copied into the entry |
| alloc_pf | input | 1 | Miss was started by a prefetch |
| alloc_state | input | 4 | Initial transient state |
| alloc_gnt | output | 1 | Allocation granted |
| alloc_idx | output | IDX_W | Granted entry index |
| alloc_stall | output | 1 | Allocation refused, table full |
| free_req | input | 1 | Release an entry |
| free_idx | input | IDX_W | Entry to release |
| st_we | input | 1 | Write the transient state of an entry |
| st_idx | input | IDX_W | Entry whose state is written |
| st_val | input | 4 | New transient state |
| rsp_valid | input | 1 | Response message present |
| rsp_idx | input | IDX_W | Entry the response belongs to |
| rsp_type | input | 3 | Response type code |
| rsp_acks | input | CNT_W | Signed ack count carried by the message |
| rsp_from_l1 | input | 1 | Sender is a peer first-level cache |
| line_state | input | 4 | Current state of the line |
| rsp_ev_valid | output | 1 | Response event valid |
| rsp_event | output | 4 | Response event code |
| rsp_cnt_after | output | CNT_W | Signed stored count after this response |
| fwd_valid | input | 1 | Forwarded request present |
| fwd_type | input | 3 | Forwarded request type code |
| fwd_ev_valid | output | 1 | Forwarded event valid |
| fwd_event | output | 4 | Forwarded event code |
| fwd_ack_cnt | output | CNT_W | Ack count for the reply (1 on invalidate) |
| rd_idx | input | IDX_W | Entry to read back |
| rd_valid | output | 1 | Read entry is allocated |
| rd_addr | output | ADDR_W | Read entry address |
| rd_state | output | 4 | Read entry transient state |
| rd_data | output | DATA_W | Read entry data copy |
| rd_dirty | output | 1 | Read entry dirty bit |
| rd_pf | output | 1 | Read entry prefetch flag |
| rd_cnt | output | CNT_W | Read entry signed ack count |
| proto_err | output | 1 | Unknown message type or unallocated entry |

## Verification
The hardest case to reach is a count that goes below zero and then comes back to exactly zero. That only happens when acks beat the data for the same miss. The stimulus allocates a fresh entry and sends two acks of one each before any data arrives, checking the partial-ack events and the counts of -1 and -2. It then delivers data carrying -2, which must be classified as final data. The peer-data path is exercised by holding the same message fixed and varying only `line_state` and `rsp_from_l1`, so a wrong choice between the peer event and the final-data event shows up directly.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  localparam int ST_W = 4;
  localparam int EV_W = 4;
  localparam int TY_W = 3;

  // line states used by the classifier
  localparam logic [ST_W-1:0] ST_RD_MISS     = 4'd5;
  localparam logic [ST_W-1:0] ST_RD_MISS_INV = 4'd8;

  // response kinds
  localparam logic [TY_W-1:0] RSP_DATA      = 3'd0;
  localparam logic [TY_W-1:0] RSP_DATA_EXCL = 3'd1;
  localparam logic [TY_W-1:0] RSP_ACK       = 3'd2;
  localparam logic [TY_W-1:0] RSP_WB_ACK    = 3'd3;

  // forwarded request kinds
  localparam logic [TY_W-1:0] FWD_INV    = 3'd0;
  localparam logic [TY_W-1:0] FWD_EXCL   = 3'd1;
  localparam logic [TY_W-1:0] FWD_UPG    = 3'd2;
  localparam logic [TY_W-1:0] FWD_SHARED = 3'd3;
  localparam logic [TY_W-1:0] FWD_INSTR  = 3'd4;

  // controller events
  localparam logic [EV_W-1:0] EV_NONE       = 4'd0;
  localparam logic [EV_W-1:0] EV_DATA_EXCL  = 4'd1;
  localparam logic [EV_W-1:0] EV_DATA_PEER  = 4'd2;
  localparam logic [EV_W-1:0] EV_DATA_FINAL = 4'd3;
  localparam logic [EV_W-1:0] EV_DATA_PART  = 4'd4;
  localparam logic [EV_W-1:0] EV_ACK_FINAL  = 4'd5;
  localparam logic [EV_W-1:0] EV_ACK_PART   = 4'd6;
  localparam logic [EV_W-1:0] EV_WB_DONE    = 4'd7;
  localparam logic [EV_W-1:0] EV_FWD_INV    = 4'd8;
  localparam logic [EV_W-1:0] EV_FWD_EXCL   = 4'd9;
  localparam logic [EV_W-1:0] EV_FWD_SHARED = 4'd10;
  localparam logic [EV_W-1:0] EV_FWD_INSTR  = 4'd11;
endpackage

// File: rtl/mtc_entry_table.sv
module mtc_entry_table
  import mtc_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 6,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int WORD_W = ADDR_W + DATA_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    alloc_req,
  input  logic [ADDR_W-1:0]       alloc_addr,
  input  logic [DATA_W-1:0]       alloc_data,
  input  logic                    alloc_dirty,
  input  logic                    alloc_pf,
  input  logic [ST_W-1:0]         alloc_state,
  output logic                    alloc_gnt,
  output logic [IDX_W-1:0]        alloc_idx,
  output logic                    alloc_stall,
  input  logic                    free_req,
  input  logic [IDX_W-1:0]        free_idx,
  input  logic                    st_we,
  input  logic [IDX_W-1:0]        st_idx,
  input  logic [ST_W-1:0]         st_val,
  input  logic [IDX_W-1:0]        look_idx,
  output logic                    look_valid,
  output logic signed [CNT_W-1:0] look_cnt,
  input  logic                    cnt_we,
  input  logic [IDX_W-1:0]        cnt_wr_idx,
  input  logic signed [CNT_W-1:0] cnt_wr_val,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic                    rd_valid,
  output logic [ADDR_W-1:0]       rd_addr,
  output logic [ST_W-1:0]         rd_state,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    rd_dirty,
  output logic                    rd_pf,
  output logic signed [CNT_W-1:0] rd_cnt
);
  logic [ENTRIES-1:0]        valid_q;
  logic signed [CNT_W-1:0]   cnt_q   [ENTRIES];
  logic [ST_W-1:0]           state_q [ENTRIES];
  logic [WORD_W-1:0]         word_mem [ENTRIES];
  logic [WORD_W-1:0]         rd_word;
  logic [IDX_W-1:0]          pick;
  logic                      found;
  logic                      take;

  // lowest free slot
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        pick  = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  assign take       = alloc_req && found;
  assign look_valid = valid_q[look_idx];
  assign look_cnt   = cnt_q[look_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q     <= '0;
      alloc_gnt   <= 1'b0;
      alloc_idx   <= '0;
      alloc_stall <= 1'b0;
    end else begin
      if (free_req) valid_q[free_idx] <= 1'b0;
      if (take) valid_q[pick] <= 1'b1;
      alloc_gnt   <= take;
      alloc_idx   <= take ? pick : alloc_idx;
      alloc_stall <= alloc_req && !found;
    end
  end

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q[g]   <= '0;
          state_q[g] <= '0;
        end else begin
          if (cnt_we && cnt_wr_idx == IDX_W'(g)) cnt_q[g] <= cnt_wr_val;
          if (st_we && st_idx == IDX_W'(g)) state_q[g] <= st_val;
          if (take && pick == IDX_W'(g)) begin
            cnt_q[g]   <= '0;
            state_q[g] <= alloc_state;
          end
        end
      end
    end
  endgenerate

  // wide payload kept in a single write port / registered read array
  always_ff @(posedge clk) begin
    if (take) word_mem[pick] <= {alloc_addr, alloc_data, alloc_dirty, alloc_pf};
    rd_word <= word_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_state <= '0;
      rd_cnt   <= '0;
    end else begin
      rd_valid <= valid_q[rd_idx];
      rd_state <= state_q[rd_idx];
      rd_cnt   <= cnt_q[rd_idx];
    end
  end

  assign rd_addr  = rd_word[WORD_W-1 -: ADDR_W];
  assign rd_data  = rd_word[DATA_W+1 -: DATA_W];
  assign rd_dirty = rd_word[1];
  assign rd_pf    = rd_word[0];

  // R2
  grant_valid_chk: assert property (@(posedge clk) disable iff (rst)
    alloc_gnt |-> valid_q[alloc_idx]);

  // R3
  full_stall_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(alloc_req) && $past(&valid_q) && !$past(rst)) |-> (alloc_stall && !alloc_gnt));

  // R4
  free_clear_chk: assert property (@(posedge clk) disable iff (rst)
    free_req |=> !valid_q[$past(free_idx)]);
endmodule

// File: rtl/mtc_rsp_decode.sv
module mtc_rsp_decode
  import mtc_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rsp_valid,
  input  logic [TY_W-1:0]         rsp_type,
  input  logic signed [CNT_W-1:0] rsp_acks,
  input  logic                    rsp_from_l1,
  input  logic [ST_W-1:0]         line_state,
  input  logic                    ent_valid,
  input  logic signed [CNT_W-1:0] stored_cnt,
  output logic                    cnt_we,
  output logic signed [CNT_W-1:0] cnt_new,
  output logic                    ev_valid,
  output logic [EV_W-1:0]         ev_code,
  output logic signed [CNT_W-1:0] cnt_after,
  output logic                    err
);
  logic signed [CNT_W-1:0] diff;
  logic                    last;
  logic                    upd;
  logic                    bad;
  logic                    err_c;
  logic                    go;
  logic [EV_W-1:0]         ev_c;

  assign diff = stored_cnt - rsp_acks;
  assign last = (diff == '0);

  always_comb begin
    upd  = 1'b0;
    bad  = 1'b0;
    ev_c = EV_NONE;
    unique case (rsp_type)
      RSP_DATA_EXCL: ev_c = EV_DATA_EXCL;
      RSP_WB_ACK:    ev_c = EV_WB_DONE;
      RSP_DATA: begin
        if (rsp_from_l1 && (line_state == ST_RD_MISS || line_state == ST_RD_MISS_INV)) begin
          ev_c = EV_DATA_PEER;
        end else begin
          upd  = 1'b1;
          ev_c = last ? EV_DATA_FINAL : EV_DATA_PART;
        end
      end
      RSP_ACK: begin
        upd  = 1'b1;
        ev_c = last ? EV_ACK_FINAL : EV_ACK_PART;
      end
      default: bad = 1'b1;
    endcase
  end

  assign err_c   = rsp_valid && (bad || !ent_valid);
  assign go      = rsp_valid && !err_c;
  assign cnt_we  = go && upd;
  assign cnt_new = diff;

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_valid  <= 1'b0;
      ev_code   <= EV_NONE;
      cnt_after <= '0;
      err       <= 1'b0;
    end else begin
      ev_valid  <= go;
      ev_code   <= go ? ev_c : EV_NONE;
      cnt_after <= upd ? diff : stored_cnt;
      err       <= err_c;
    end
  end

  // R11
  stale_entry_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rsp_valid) && !$past(ent_valid) && !$past(rst)) |-> (err && !ev_valid));
endmodule

// File: rtl/mtc_fwd_decode.sv
module mtc_fwd_decode
  import mtc_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fwd_valid,
  input  logic [TY_W-1:0]  fwd_type,
  output logic             ev_valid,
  output logic [EV_W-1:0]  ev_code,
  output logic [CNT_W-1:0] ack_cnt,
  output logic             err
);
  logic [EV_W-1:0] ev_c;
  logic            bad;

  always_comb begin
    bad  = 1'b0;
    ev_c = EV_NONE;
    unique case (fwd_type)
      FWD_INV:            ev_c = EV_FWD_INV;
      FWD_EXCL, FWD_UPG:  ev_c = EV_FWD_EXCL;
      FWD_SHARED:         ev_c = EV_FWD_SHARED;
      FWD_INSTR:          ev_c = EV_FWD_INSTR;
      default:            bad  = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_valid <= 1'b0;
      ev_code  <= EV_NONE;
      ack_cnt  <= '0;
      err      <= 1'b0;
    end else begin
      ev_valid <= fwd_valid && !bad;
      ev_code  <= (fwd_valid && !bad) ? ev_c : EV_NONE;
      ack_cnt  <= (fwd_valid && fwd_type == FWD_INV) ? CNT_W'(1) : '0;
      err      <= fwd_valid && bad;
    end
  end

  // R10
  upgrade_fold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(fwd_valid) && $past(fwd_type) == FWD_UPG && !$past(rst)) |-> (ev_valid && ev_code == EV_FWD_EXCL));

  // R10
  inv_one_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_code == EV_FWD_INV) |-> (ack_cnt == CNT_W'(1)));
endmodule

// File: rtl/miss_resp_classifier.sv
module miss_resp_classifier
  import mtc_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 6,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    alloc_req,
  input  logic [ADDR_W-1:0]       alloc_addr,
  input  logic [DATA_W-1:0]       alloc_data,
  input  logic                    alloc_dirty,
  input  logic                    alloc_pf,
  input  logic [3:0]              alloc_state,
  output logic                    alloc_gnt,
  output logic [IDX_W-1:0]        alloc_idx,
  output logic                    alloc_stall,
  input  logic                    free_req,
  input  logic [IDX_W-1:0]        free_idx,
  input  logic                    st_we,
  input  logic [IDX_W-1:0]        st_idx,
  input  logic [3:0]              st_val,
  input  logic                    rsp_valid,
  input  logic [IDX_W-1:0]        rsp_idx,
  input  logic [2:0]              rsp_type,
  input  logic signed [CNT_W-1:0] rsp_acks,
  input  logic                    rsp_from_l1,
  input  logic [3:0]              line_state,
  output logic                    rsp_ev_valid,
  output logic [3:0]              rsp_event,
  output logic signed [CNT_W-1:0] rsp_cnt_after,
  input  logic                    fwd_valid,
  input  logic [2:0]              fwd_type,
  output logic                    fwd_ev_valid,
  output logic [3:0]              fwd_event,
  output logic [CNT_W-1:0]        fwd_ack_cnt,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic                    rd_valid,
  output logic [ADDR_W-1:0]       rd_addr,
  output logic [3:0]              rd_state,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    rd_dirty,
  output logic                    rd_pf,
  output logic signed [CNT_W-1:0] rd_cnt,
  output logic                    proto_err
);
  logic                    ent_valid;
  logic signed [CNT_W-1:0] stored_cnt;
  logic                    cnt_we;
  logic signed [CNT_W-1:0] cnt_new;
  logic                    rsp_err;
  logic                    fwd_err;

  mtc_entry_table #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_tab (
    .clk(clk), .rst(rst),
    .alloc_req(alloc_req), .alloc_addr(alloc_addr), .alloc_data(alloc_data),
    .alloc_dirty(alloc_dirty), .alloc_pf(alloc_pf), .alloc_state(alloc_state),
    .alloc_gnt(alloc_gnt), .alloc_idx(alloc_idx), .alloc_stall(alloc_stall),
    .free_req(free_req), .free_idx(free_idx),
    .st_we(st_we), .st_idx(st_idx), .st_val(st_val),
    .look_idx(rsp_idx), .look_valid(ent_valid), .look_cnt(stored_cnt),
    .cnt_we(cnt_we), .cnt_wr_idx(rsp_idx), .cnt_wr_val(cnt_new),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_state(rd_state),
    .rd_data(rd_data), .rd_dirty(rd_dirty), .rd_pf(rd_pf), .rd_cnt(rd_cnt)
  );

  mtc_rsp_decode #(.CNT_W(CNT_W)) u_rsp (
    .clk(clk), .rst(rst),
    .rsp_valid(rsp_valid), .rsp_type(rsp_type), .rsp_acks(rsp_acks),
    .rsp_from_l1(rsp_from_l1), .line_state(line_state),
    .ent_valid(ent_valid), .stored_cnt(stored_cnt),
    .cnt_we(cnt_we), .cnt_new(cnt_new),
    .ev_valid(rsp_ev_valid), .ev_code(rsp_event), .cnt_after(rsp_cnt_after),
    .err(rsp_err)
  );

  mtc_fwd_decode #(.CNT_W(CNT_W)) u_fwd (
    .clk(clk), .rst(rst),
    .fwd_valid(fwd_valid), .fwd_type(fwd_type),
    .ev_valid(fwd_ev_valid), .ev_code(fwd_event), .ack_cnt(fwd_ack_cnt),
    .err(fwd_err)
  );

  assign proto_err = rsp_err | fwd_err;

  // R7
  data_final_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_ev_valid && rsp_event == EV_DATA_FINAL) |-> (u_tab.cnt_q[$past(rsp_idx)] == '0));

  // R8
  ack_final_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_ev_valid && rsp_event == EV_ACK_FINAL) |-> (u_tab.cnt_q[$past(rsp_idx)] == '0));

  // R6
  peer_keeps_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_ev_valid && rsp_event == EV_DATA_PEER) |-> (u_tab.cnt_q[$past(rsp_idx)] == $past(stored_cnt)));
endmodule

// File: tb/miss_resp_classifier_bench.sv
`timescale 1ns/100ps
module miss_resp_classifier_bench;
  localparam int ENTRIES = 4;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 6;
  localparam int IDX_W   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic alloc_req = 0; logic [ADDR_W-1:0] alloc_addr = '0; logic [DATA_W-1:0] alloc_data = '0;
  logic alloc_dirty = 0; logic alloc_pf = 0; logic [3:0] alloc_state = '0;
  logic alloc_gnt; logic [IDX_W-1:0] alloc_idx; logic alloc_stall;
  logic free_req = 0; logic [IDX_W-1:0] free_idx = '0;
  logic st_we = 0; logic [IDX_W-1:0] st_idx = '0; logic [3:0] st_val = '0;
  logic rsp_valid = 0; logic [IDX_W-1:0] rsp_idx = '0; logic [2:0] rsp_type = '0;
  logic signed [CNT_W-1:0] rsp_acks = '0; logic rsp_from_l1 = 0; logic [3:0] line_state = '0;
  logic rsp_ev_valid; logic [3:0] rsp_event; logic signed [CNT_W-1:0] rsp_cnt_after;
  logic fwd_valid = 0; logic [2:0] fwd_type = '0;
  logic fwd_ev_valid; logic [3:0] fwd_event; logic [CNT_W-1:0] fwd_ack_cnt;
  logic [IDX_W-1:0] rd_idx = '0;
  logic rd_valid; logic [ADDR_W-1:0] rd_addr; logic [3:0] rd_state; logic [DATA_W-1:0] rd_data;
  logic rd_dirty; logic rd_pf; logic signed [CNT_W-1:0] rd_cnt; logic proto_err;

  miss_resp_classifier #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_miss_resp_classifier (
    .clk(clk), .rst(rst),
    .alloc_req(alloc_req), .alloc_addr(alloc_addr), .alloc_data(alloc_data),
    .alloc_dirty(alloc_dirty), .alloc_pf(alloc_pf), .alloc_state(alloc_state),
    .alloc_gnt(alloc_gnt), .alloc_idx(alloc_idx), .alloc_stall(alloc_stall),
    .free_req(free_req), .free_idx(free_idx),
    .st_we(st_we), .st_idx(st_idx), .st_val(st_val),
    .rsp_valid(rsp_valid), .rsp_idx(rsp_idx), .rsp_type(rsp_type), .rsp_acks(rsp_acks),
    .rsp_from_l1(rsp_from_l1), .line_state(line_state),
    .rsp_ev_valid(rsp_ev_valid), .rsp_event(rsp_event), .rsp_cnt_after(rsp_cnt_after),
    .fwd_valid(fwd_valid), .fwd_type(fwd_type),
    .fwd_ev_valid(fwd_ev_valid), .fwd_event(fwd_event), .fwd_ack_cnt(fwd_ack_cnt),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_state(rd_state),
    .rd_data(rd_data), .rd_dirty(rd_dirty), .rd_pf(rd_pf), .rd_cnt(rd_cnt),
    .proto_err(proto_err)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_alloc(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                          input logic dty, input logic pf, input logic [3:0] st);
    @(negedge clk);
    alloc_req = 1; alloc_addr = a; alloc_data = d; alloc_dirty = dty; alloc_pf = pf; alloc_state = st;
    @(negedge clk);
    alloc_req = 0;
  endtask

  task automatic do_free(input int idx);
    @(negedge clk);
    free_req = 1; free_idx = IDX_W'(idx);
    @(negedge clk);
    free_req = 0;
  endtask

  task automatic do_rsp(input int idx, input int ty, input int acks, input logic l1, input int st);
    @(negedge clk);
    rsp_valid = 1; rsp_idx = IDX_W'(idx); rsp_type = 3'(ty);
    rsp_acks = CNT_W'(acks); rsp_from_l1 = l1; line_state = 4'(st);
    @(negedge clk);
    rsp_valid = 0;
  endtask

  task automatic do_fwd(input int ty);
    @(negedge clk);
    fwd_valid = 1; fwd_type = 3'(ty);
    @(negedge clk);
    fwd_valid = 0;
  endtask

  task automatic do_read(input int idx);
    @(negedge clk);
    rd_idx = IDX_W'(idx);
    @(negedge clk);
  endtask

  task automatic rsp_expect(input string req, input int ev, input int cnt);
    chk(req, "rsp_ev_valid", int'(rsp_ev_valid), 1);
    chk(req, "rsp_event", int'(rsp_event), ev);
    chk(req, "rsp_cnt_after", int'(rsp_cnt_after), cnt);
  endtask

  task automatic t_reset();
    do_read(0);
    chk("R1", "alloc_gnt", int'(alloc_gnt), 0);
    chk("R1", "alloc_stall", int'(alloc_stall), 0);
    chk("R1", "rsp_ev_valid", int'(rsp_ev_valid), 0);
    chk("R1", "fwd_ev_valid", int'(fwd_ev_valid), 0);
    chk("R1", "proto_err", int'(proto_err), 0);
    chk("R1", "rd_valid", int'(rd_valid), 0);
  endtask

  task automatic t_alloc_copy();
    do_alloc(16'hA5C3, 32'hDEAD_BEEF, 1'b1, 1'b1, 4'd6);
    chk("R2", "alloc_gnt", int'(alloc_gnt), 1);
    chk("R2", "alloc_idx", int'(alloc_idx), 0);
    do_read(0);
    chk("R2", "rd_valid", int'(rd_valid), 1);
    chk("R2", "rd_addr", int'(rd_addr), 16'hA5C3);
    chk("R2", "rd_data", int'(rd_data), 32'hDEAD_BEEF);
    chk("R2", "rd_dirty", int'(rd_dirty), 1);
    chk("R2", "rd_pf", int'(rd_pf), 1);
    chk("R2", "rd_state", int'(rd_state), 6);
    chk("R2", "rd_cnt", int'(rd_cnt), 0);
  endtask

  task automatic t_write_miss_counts();
    do_rsp(0, 0, -2, 1'b0, 6);
    rsp_expect("R7", 4, 2);
    do_rsp(0, 2, 1, 1'b0, 6);
    rsp_expect("R8", 6, 1);
    do_rsp(0, 2, 1, 1'b0, 6);
    rsp_expect("R8", 5, 0);
    do_read(0);
    chk("R8", "rd_cnt", int'(rd_cnt), 0);
  endtask

  task automatic t_acks_first();
    do_alloc(16'h0042, 32'h1234_5678, 1'b0, 1'b0, 4'd6);
    chk("R2", "alloc_idx lowest free", int'(alloc_idx), 1);
    do_rsp(1, 2, 1, 1'b0, 6);
    rsp_expect("R9", 6, -1);
    do_rsp(1, 2, 1, 1'b0, 6);
    rsp_expect("R9", 6, -2);
    do_read(1);
    chk("R9", "rd_cnt negative", int'(rd_cnt), -2);
    do_rsp(1, 0, -2, 1'b0, 6);
    rsp_expect("R7", 3, 0);
  endtask

  task automatic t_peer_data();
    do_rsp(1, 0, 7, 1'b1, 5);
    rsp_expect("R6", 2, 0);
    do_rsp(1, 0, 7, 1'b1, 8);
    rsp_expect("R6", 2, 0);
    do_read(1);
    chk("R6", "rd_cnt unchanged", int'(rd_cnt), 0);
    do_rsp(1, 0, 0, 1'b1, 6);
    rsp_expect("R7", 3, 0);
    do_rsp(1, 0, 3, 1'b0, 5);
    rsp_expect("R7", 4, -3);
  endtask

  task automatic t_excl_wb();
    do_rsp(0, 1, 4, 1'b0, 5);
    rsp_expect("R5", 1, 0);
    do_rsp(0, 3, 4, 1'b0, 9);
    rsp_expect("R5", 7, 0);
    do_read(0);
    chk("R5", "rd_cnt unchanged", int'(rd_cnt), 0);
  endtask

  task automatic t_fwd();
    do_fwd(0);
    chk("R10", "inv event", int'(fwd_event), 8);
    chk("R10", "inv ack count", int'(fwd_ack_cnt), 1);
    do_fwd(1);
    chk("R10", "excl event", int'(fwd_event), 9);
    chk("R10", "excl ack count", int'(fwd_ack_cnt), 0);
    do_fwd(2);
    chk("R10", "upgrade event", int'(fwd_event), 9);
    do_fwd(3);
    chk("R10", "shared event", int'(fwd_event), 10);
    do_fwd(4);
    chk("R10", "instr event", int'(fwd_event), 11);
    chk("R10", "fwd_ev_valid", int'(fwd_ev_valid), 1);
  endtask

  task automatic t_errors();
    do_rsp(0, 5, 0, 1'b0, 6);
    chk("R11", "bad rsp proto_err", int'(proto_err), 1);
    chk("R11", "bad rsp no event", int'(rsp_ev_valid), 0);
    do_fwd(6);
    chk("R11", "bad fwd proto_err", int'(proto_err), 1);
    chk("R11", "bad fwd no event", int'(fwd_ev_valid), 0);
    do_rsp(3, 2, 0, 1'b0, 6);
    chk("R11", "stale entry proto_err", int'(proto_err), 1);
    chk("R11", "stale entry no event", int'(rsp_ev_valid), 0);
    @(negedge clk);
    chk("R11", "pulse ends", int'(proto_err), 0);
  endtask

  task automatic t_full_and_reuse();
    do_alloc(16'h0002, 32'h2, 1'b0, 1'b0, 4'd5);
    chk("R2", "third idx", int'(alloc_idx), 2);
    do_alloc(16'h0003, 32'h3, 1'b0, 1'b0, 4'd5);
    chk("R2", "fourth idx", int'(alloc_idx), 3);
    do_alloc(16'h0004, 32'h4, 1'b0, 1'b0, 4'd5);
    chk("R3", "alloc_stall", int'(alloc_stall), 1);
    chk("R3", "alloc_gnt", int'(alloc_gnt), 0);
    do_free(1);
    do_read(1);
    chk("R4", "freed rd_valid", int'(rd_valid), 0);
    do_alloc(16'h0077, 32'h77, 1'b0, 1'b0, 4'd5);
    chk("R4", "reuse grant", int'(alloc_gnt), 1);
    chk("R4", "reuse idx", int'(alloc_idx), 1);
    chk("R4", "no stall", int'(alloc_stall), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_alloc_copy();
    t_write_miss_counts();
    t_acks_first();
    t_peer_data();
    t_excl_wb();
    t_fwd();
    t_errors();
    t_full_and_reuse();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule